// File: doc/BRIEF.md
# Block-Copy Address Sequencer

This block is the control and address core of a two-dimensional block-copy engine. Software programs it over a simple 32-bit register bus with the source and destination line pitch, the two start addresses, a pair of direction bits and the rectangle size. Writing the size register is itself the start command. The sequencer then visits every byte of the rectangle. For each byte it issues one source read request and then one destination write request on a single valid/ready request channel.

Each axis has its own direction bit, so software can pick a walk order that stays safe when the source and destination rectangles overlap. The start addresses name the first byte visited. In a reverse mode that is the rightmost byte or the bottom line. While a transfer runs, a busy output and a read-only status bit are high. A one-cycle done pulse marks the acceptance of the final destination write. Pixel data, combining logic and the memory itself live outside this block.

Top module: `blit_addr_seq`

## Requirements
- R1: After reset the block is idle: busy and req_valid are 0, done is 0, and every register reads back 0.
- R2: Source and destination start addresses are 21-bit byte addresses (register index 2 for source, 3 for destination). Written bits above bit 20 are dropped and read back as 0.
- R3: The pitch register (index 0) keeps the source pitch in bits 11:0 and the destination pitch in bits 27:16. All other bits read 0.
- R4: A write to the size register (index 4, bytes per line in bits 11:0, line count in bits 27:16) while idle latches the size and starts a transfer. busy and bit 20 of the control register (index 1) read 1 from the next cycle until the transfer ends.
- R5: For each byte, a source read request (req_write=0) is accepted before the matching destination write request (req_write=1). Read and write requests alternate strictly.
- R6: Control bit 9 selects the byte order within a line. With 1 the address rises by one per byte; with 0 it falls by one. Addresses wrap modulo 2^21.
- R7: Control bit 8 selects the line order. With 1 each new line base is the previous base plus the pitch; with 0 it is the previous base minus the pitch. The byte address restarts at the new line base.
- R8: A start with zero width or zero height issues no memory request. It pulses done in the cycle after the write, and busy stays 0.
- R9: Writes to any register while busy are ignored. They change neither the read-back value nor the running transfer, and a size write does not restart it.
- R10: done is high for exactly one cycle: the cycle in which the last destination write is accepted. busy is 0 in the cycle after.
- R11: While req_valid is high and req_ready is low, req_valid, req_addr and req_write hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read-back of the register selected by reg_idx |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory request accepted |
| req_write | output | 1 | 0 = source read, 1 = destination write |
| req_addr | output | 21 | Byte address of the request |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse on final destination write acceptance |

## Verification
A wrong line base or a bad direction choice shows at req_addr on the first request of the affected line or byte. That is at most two accepted requests after the faulty step, so the bench compares every accepted address with a value it derives from base, pitch and direction. A column or row counter that drifts shows up as too few or too many requests, or as done at the wrong handshake. Corrupted configuration during a busy write shows in later addresses and in the read-back after completion.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int ADDR_W = 21;
  localparam int LEN_W  = 12;
  localparam int IDX_W  = 3;

  localparam logic [IDX_W-1:0] IDX_PITCH = 3'd0;
  localparam logic [IDX_W-1:0] IDX_CTRL  = 3'd1;
  localparam logic [IDX_W-1:0] IDX_SRC   = 3'd2;
  localparam logic [IDX_W-1:0] IDX_DST   = 3'd3;
  localparam logic [IDX_W-1:0] IDX_SIZE  = 3'd4;

  localparam int CTRL_YFWD_BIT = 8;
  localparam int CTRL_XFWD_BIT = 9;
  localparam int CTRL_BUSY_BIT = 20;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} walk_state_t;

  // Move an address forward or backward by an amount, wrapping at the address width.
  function automatic logic [ADDR_W-1:0] step_addr(
    input logic [ADDR_W-1:0] a,
    input logic [LEN_W-1:0]  amt,
    input logic              fwd
  );
    logic [ADDR_W-1:0] ext;
    ext = ADDR_W'(amt);
    return fwd ? a + ext : a - ext;
  endfunction
endpackage

// File: rtl/blit_regs.sv
module blit_regs
  import blit_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int LW = LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  input  logic             busy,
  output logic [31:0]      rdata,
  output logic [LW-1:0]    src_pitch,
  output logic [LW-1:0]    dst_pitch,
  output logic [AW-1:0]    src_base,
  output logic [AW-1:0]    dst_base,
  output logic             x_fwd,
  output logic             y_fwd,
  output logic             start,
  output logic [LW-1:0]    start_w,
  output logic [LW-1:0]    start_h
);
  localparam int HI_OFS = 16;

  logic [LW-1:0] width_q, height_q;
  logic          wr_ok;
  logic          unused_wbits;

  assign wr_ok   = wr_en && !busy;
  assign start   = wr_ok && (idx == IDX_SIZE);
  assign start_w = wdata[LW-1:0];
  assign start_h = wdata[HI_OFS+LW-1:HI_OFS];
  assign unused_wbits = &{wdata[31:HI_OFS+LW], wdata[HI_OFS-1:LW]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_pitch <= '0;
      dst_pitch <= '0;
      src_base  <= '0;
      dst_base  <= '0;
      x_fwd     <= 1'b0;
      y_fwd     <= 1'b0;
      width_q   <= '0;
      height_q  <= '0;
    end else if (wr_ok) begin
      case (idx)
        IDX_PITCH: begin
          src_pitch <= wdata[LW-1:0];
          dst_pitch <= wdata[HI_OFS+LW-1:HI_OFS];
        end
        IDX_CTRL: begin
          y_fwd <= wdata[CTRL_YFWD_BIT];
          x_fwd <= wdata[CTRL_XFWD_BIT];
        end
        IDX_SRC:  src_base <= wdata[AW-1:0];
        IDX_DST:  dst_base <= wdata[AW-1:0];
        IDX_SIZE: begin
          width_q  <= start_w;
          height_q <= start_h;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (idx)
      IDX_PITCH: begin
        rdata[LW-1:0]              = src_pitch;
        rdata[HI_OFS+LW-1:HI_OFS]  = dst_pitch;
      end
      IDX_CTRL: begin
        rdata[CTRL_YFWD_BIT] = y_fwd;
        rdata[CTRL_XFWD_BIT] = x_fwd;
        rdata[CTRL_BUSY_BIT] = busy;
      end
      IDX_SRC:  rdata[AW-1:0] = src_base;
      IDX_DST:  rdata[AW-1:0] = dst_base;
      IDX_SIZE: begin
        rdata[LW-1:0]             = width_q;
        rdata[HI_OFS+LW-1:HI_OFS] = height_q;
      end
      default: rdata = '0;
    endcase
  end

  AST_BUSY_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> ($stable(src_base) && $stable(dst_base) && $stable(src_pitch) && $stable(dst_pitch) && $stable(x_fwd) && $stable(y_fwd))); // R9
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start); // R9
endmodule

// File: rtl/blit_walker.sv
module blit_walker
  import blit_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int LW = LEN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] start_w,
  input  logic [LW-1:0] start_h,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic [LW-1:0] src_pitch,
  input  logic [LW-1:0] dst_pitch,
  input  logic          x_fwd,
  input  logic          y_fwd,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic          busy,
  output logic          done
);
  walk_state_t   state_q;
  logic [LW-1:0] width_q, height_q, col_q, row_q;
  logic [AW-1:0] src_line_q, dst_line_q, src_cur_q, dst_cur_q;
  logic          zero_done_q;

  // Named internal events
  logic rd_accept, wr_accept, line_end, last_line;
  logic byte_step, line_step, last_accept, zero_start;
  logic [AW-1:0] nxt_src_line, nxt_dst_line;

  assign rd_accept   = (state_q == ST_RD) && req_ready;
  assign wr_accept   = (state_q == ST_WR) && req_ready;
  assign line_end    = (col_q == width_q - LW'(1));
  assign last_line   = (row_q == height_q - LW'(1));
  assign byte_step   = wr_accept && !line_end;
  assign line_step   = wr_accept && line_end && !last_line;
  assign last_accept = wr_accept && line_end && last_line;
  assign zero_start  = start && (start_w == '0 || start_h == '0);

  assign nxt_src_line = step_addr(src_line_q, src_pitch, y_fwd);
  assign nxt_dst_line = step_addr(dst_line_q, dst_pitch, y_fwd);

  assign req_valid = (state_q != ST_IDLE);
  assign req_write = (state_q == ST_WR);
  assign req_addr  = (state_q == ST_WR) ? dst_cur_q : src_cur_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = last_accept || zero_done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      width_q     <= '0;
      height_q    <= '0;
      col_q       <= '0;
      row_q       <= '0;
      src_line_q  <= '0;
      dst_line_q  <= '0;
      src_cur_q   <= '0;
      dst_cur_q   <= '0;
      zero_done_q <= 1'b0;
    end else begin
      zero_done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            width_q    <= start_w;
            height_q   <= start_h;
            col_q      <= '0;
            row_q      <= '0;
            src_line_q <= src_base;
            dst_line_q <= dst_base;
            src_cur_q  <= src_base;
            dst_cur_q  <= dst_base;
            if (zero_start) zero_done_q <= 1'b1;
            else            state_q     <= ST_RD;
          end
        end
        ST_RD: begin
          if (rd_accept) state_q <= ST_WR;
        end
        ST_WR: begin
          if (last_accept) begin
            state_q <= ST_IDLE;
          end else if (line_step) begin
            row_q      <= row_q + LW'(1);
            col_q      <= '0;
            src_line_q <= nxt_src_line;
            dst_line_q <= nxt_dst_line;
            src_cur_q  <= nxt_src_line;
            dst_cur_q  <= nxt_dst_line;
            state_q    <= ST_RD;
          end else if (byte_step) begin
            col_q     <= col_q + LW'(1);
            src_cur_q <= step_addr(src_cur_q, LW'(1), x_fwd);
            dst_cur_q <= step_addr(dst_cur_q, LW'(1), x_fwd);
            state_q   <= ST_RD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_write))); // R11
  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> (req_valid && req_write)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    last_accept |=> !busy); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid); // R8
  AST_ZERO_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    zero_start |=> (!busy && done)); // R8
endmodule

// File: rtl/blit_addr_seq.sv
module blit_addr_seq
  import blit_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int LW = LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             req_valid,
  input  logic             req_ready,
  output logic             req_write,
  output logic [AW-1:0]    req_addr,
  output logic             busy,
  output logic             done
);
  logic [LW-1:0] src_pitch, dst_pitch, start_w, start_h;
  logic [AW-1:0] src_base, dst_base;
  logic          x_fwd, y_fwd, start;

  blit_regs #(.AW(AW), .LW(LW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .idx(reg_idx), .wdata(reg_wdata),
    .busy(busy), .rdata(reg_rdata), .src_pitch(src_pitch), .dst_pitch(dst_pitch),
    .src_base(src_base), .dst_base(dst_base), .x_fwd(x_fwd), .y_fwd(y_fwd),
    .start(start), .start_w(start_w), .start_h(start_h)
  );

  blit_walker #(.AW(AW), .LW(LW)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .start_w(start_w), .start_h(start_h),
    .src_base(src_base), .dst_base(dst_base), .src_pitch(src_pitch),
    .dst_pitch(dst_pitch), .x_fwd(x_fwd), .y_fwd(y_fwd),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .busy(busy), .done(done)
  );

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == IDX_SIZE && !busy && reg_wdata[LW-1:0] != '0 && reg_wdata[16+LW-1:16] != '0) |=> busy); // R4
endmodule

// File: tb/blit_addr_seq_tb.sv
module blit_addr_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_idx = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        req_valid, req_write, busy, done;
  logic        req_ready = 1'b0;
  logic [20:0] req_addr;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blit_addr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] idx, input logic [31:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = idx; reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] idx, output logic [31:0] data);
    reg_idx = idx;
    #1;
    data = reg_rdata;
  endtask

  function automatic logic [20:0] exp_addr(input logic [31:0] base, input logic [31:0] pitch,
                                           input bit xf, input bit yf, input int line, input int b);
    logic [31:0] a;
    a = yf ? base + pitch * line : base - pitch * line;
    a = xf ? a + b : a - b;
    return a[20:0];
  endfunction

  // Drive ready, record every handshake and compare it with the walk order.
  task automatic collect(input logic [31:0] sb, input logic [31:0] db, input logic [31:0] sp,
                         input logic [31:0] dp, input bit xf, input bit yf, input int w, input int h,
                         input bit stall, input string tag);
    int k = 0;
    int total = 2 * w * h;
    int cyc = 0;
    bit held = 0;
    logic [20:0] held_addr = '0;
    while (k < total && cyc < 8 * total + 50) begin
      req_ready = stall ? ((cyc % 3) != 1) : 1'b1;
      #1;
      if (held) begin
        check(req_valid && req_addr == held_addr, "R11 hold while stalled", {11'd0, req_addr}, {11'd0, held_addr});
      end
      held = 0;
      if (req_valid && !req_ready) begin
        held = 1; held_addr = req_addr;
      end
      if (req_valid && req_ready) begin
        int n = k / 2;
        int line = n / w;
        int b = n % w;
        bit wr = (k % 2) == 1;
        logic [20:0] e = wr ? exp_addr(db, dp, xf, yf, line, b) : exp_addr(sb, sp, xf, yf, line, b);
        check(req_write == wr, {tag, " R5 read/write order"}, {31'd0, req_write}, {31'd0, wr});
        check(req_addr == e, {tag, " R6/R7 address"}, {11'd0, req_addr}, {11'd0, e});
        check(done == (k == total - 1), {tag, " R10 done timing"}, {31'd0, done}, {31'd0, k == total - 1});
        k++;
      end else begin
        check(!done, {tag, " R10 no stray done"}, {31'd0, done}, 32'd0);
      end
      @(negedge clk);
      cyc++;
    end
    req_ready = 1'b0;
    check(k == total, {tag, " R9 request count"}, k, total);
    #1;
    check(!busy && !done, {tag, " R10 idle after last write"}, {30'd0, busy, done}, 32'd0);
  endtask

  task automatic setup(input logic [31:0] sb, input logic [31:0] db, input logic [31:0] sp,
                       input logic [31:0] dp, input bit xf, input bit yf);
    reg_write(3'd0, {4'd0, dp[11:0], 4'd0, sp[11:0]});
    reg_write(3'd1, (32'(xf) << 9) | (32'(yf) << 8));
    reg_write(3'd2, sb);
    reg_write(3'd3, db);
  endtask

  task automatic start_size(input int w, input int h);
    logic [31:0] rd;
    reg_write(3'd4, {4'd0, 12'(h), 4'd0, 12'(w)});
    reg_read(3'd1, rd);
    check(busy == 1'b1, "R4 busy after start", {31'd0, busy}, 32'd1);
    check(rd[20] == 1'b1, "R4 status bit 20", rd, rd | 32'h0010_0000);
  endtask

  task automatic run_xfer(input logic [31:0] sb, input logic [31:0] db, input logic [31:0] sp,
                          input logic [31:0] dp, input bit xf, input bit yf, input int w, input int h,
                          input bit stall, input string tag);
    logic [31:0] rd;
    setup(sb, db, sp, dp, xf, yf);
    start_size(w, h);
    reg_read(3'd4, rd);
    check(rd == {4'd0, 12'(h), 4'd0, 12'(w)}, "R4 size readback", rd, {4'd0, 12'(h), 4'd0, 12'(w)});
    collect(sb, db, sp, dp, xf, yf, w, h, stall, tag);
  endtask

  task automatic t_reset;
    logic [31:0] rd;
    #1;
    check(!busy && !req_valid && !done, "R1 idle outputs", {29'd0, busy, req_valid, done}, 32'd0);
    for (int i = 0; i < 5; i++) begin
      reg_read(3'(i), rd);
      check(rd == 32'd0, "R1 register reset value", rd, 32'd0);
    end
  endtask

  task automatic t_masking;
    logic [31:0] rd;
    reg_write(3'd2, 32'hFFE0_0123);
    reg_read(3'd2, rd);
    check(rd == 32'h0000_0123, "R2 source high bits dropped", rd, 32'h0000_0123);
    reg_write(3'd3, 32'hABFF_FFFF);
    reg_read(3'd3, rd);
    check(rd == 32'h001F_FFFF, "R2 destination high bits dropped", rd, 32'h001F_FFFF);
    reg_write(3'd0, 32'hFFFF_FFFF);
    reg_read(3'd0, rd);
    check(rd == 32'h0FFF_0FFF, "R3 pitch reserved bits", rd, 32'h0FFF_0FFF);
    reg_write(3'd0, 32'h0123_0456);
    reg_read(3'd0, rd);
    check(rd == 32'h0123_0456, "R3 pitch fields", rd, 32'h0123_0456);
  endtask

  task automatic t_zero(input int w, input int h);
    reg_write(3'd4, {4'd0, 12'(h), 4'd0, 12'(w)});
    #1;
    check(done == 1'b1, "R8 zero size done pulse", {31'd0, done}, 32'd1);
    check(!busy && !req_valid, "R8 zero size no request", {30'd0, busy, req_valid}, 32'd0);
    @(negedge clk); #1;
    check(!done && !req_valid, "R10 zero done single cycle", {30'd0, done, req_valid}, 32'd0);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] rd;
    setup(32'h0000_1000, 32'h0000_2000, 32'd64, 32'd64, 1'b1, 1'b1);
    start_size(2, 2);
    reg_write(3'd2, 32'h0005_5555);
    reg_write(3'd0, 32'h0001_0001);
    reg_write(3'd1, 32'h0);
    reg_write(3'd4, {4'd0, 12'd9, 4'd0, 12'd9});
    collect(32'h0000_1000, 32'h0000_2000, 32'd64, 32'd64, 1'b1, 1'b1, 2, 2, 1'b0, "busy-ignore");
    reg_read(3'd2, rd);
    check(rd == 32'h0000_1000, "R9 source kept", rd, 32'h0000_1000);
    reg_read(3'd0, rd);
    check(rd == 32'h0040_0040, "R9 pitch kept", rd, 32'h0040_0040);
    reg_read(3'd4, rd);
    check(rd == 32'h0002_0002, "R9 size kept", rd, 32'h0002_0002);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_masking();
    run_xfer(32'h100, 32'h800, 32'd16, 32'd32, 1'b1, 1'b1, 3, 2, 1'b0, "fwd");
    run_xfer(32'h1FF, 32'h9FF, 32'd20, 32'd40, 1'b0, 1'b0, 4, 3, 1'b1, "rev");
    run_xfer(32'h001, 32'h400, 32'd8, 32'd8, 1'b0, 1'b1, 3, 2, 1'b0, "wrap-x");
    run_xfer(32'h010, 32'h1F_FFF0, 32'd100, 32'h300, 1'b1, 1'b0, 2, 3, 1'b1, "wrap-y");
    run_xfer(32'h500, 32'h600, 32'd0, 32'd0, 1'b1, 1'b1, 1, 1, 1'b1, "single");
    t_zero(0, 5);
    t_zero(7, 0);
    t_busy_ignore();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule